// File: doc/BRIEF.md
# Multi-Unicast Distribution Vector Expander

This block turns one activation descriptor into a stream of unicast send requests. The descriptor carries a 256-bit distribution vector, a 15-bit base node field, an 8-bit command, a message payload and a multilevel flag. Each set bit of the vector names one destination. That destination's node identifier is the base field plus the bit's index. Adjacent vector bits stand for consecutive even node identifiers, and the base holds a node identifier shifted right by one.

The block walks the vector from index 0 upward. It emits one request per cycle while the consumer holds `req_ready` high, and it jumps straight over clear bits. After the last request it pulses `done`, and only then does it take the next descriptor. An all-zero vector gives a `done` pulse and no requests. Only endpoint multi-unicast mode is handled. A descriptor with the multilevel flag set gives an error pulse and no requests. The endpoint message command is normally 0x38, and the block forwards the command unchanged.

The controller has four states. ST_IDLE waits for a descriptor. ST_EMIT presents requests. ST_DONE is the one-cycle end-of-vector pulse. ST_FAULT is the one-cycle unsupported-mode pulse. The transitions are:
- ST_IDLE to ST_EMIT on accepting a non-empty vector.
- ST_IDLE to ST_DONE on accepting an empty vector.
- ST_IDLE to ST_FAULT on accepting a multilevel descriptor.
- ST_EMIT to itself while requests remain.
- ST_EMIT to ST_DONE on the handshake of the last request.
- ST_DONE and ST_FAULT back to ST_IDLE unconditionally.

Top module: `ucast_fanout`

## Requirements
- R1: While reset is active, and in the first cycle after it, `desc_ready` is 1 and `req_valid`, `done` and `err_mode` are 0.
- R2: A descriptor is taken on a clock edge where `desc_ready` and `desc_valid` are both 1. `desc_ready` is then 0 until the cycle after the `done` or `err_mode` pulse, and it is never 1 while `req_valid` is 1.
- R3: For a taken descriptor with multilevel flag 0, exactly one request is made per set vector bit, in ascending bit index. The first request is valid in the cycle after acceptance, and each following request is valid in the cycle after the previous handshake, with no idle cycles for clear bits.
- R4: Each request carries `req_index` equal to its bit index and `req_node` equal to (base + index) modulo 2^15. It also carries the command and payload captured at acceptance.
- R5: While `req_valid` is 1 and `req_ready` is 0, the request stays valid, and its node, index, command and payload do not change.
- R6: `done` is 1 for exactly one cycle. That cycle follows the handshake of the last request, or, for an all-zero vector, follows acceptance with no request at all.
- R7: A descriptor taken with `desc_multilevel` = 1 makes `err_mode` 1 for exactly the cycle after acceptance. No request and no `done` follow.
- R8: `desc_valid` and the descriptor inputs are ignored while a descriptor is in progress. The request stream and `done` timing are unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block is idle and takes a descriptor |
| desc_vec | input | VEC_W (256) | Distribution vector, bit i targets base + i |
| desc_base | input | NODE_W (15) | Base node identifier (node ID shifted right by one) |
| desc_cmd | input | CMD_W (8) | Message command, forwarded with each request |
| desc_multilevel | input | 1 | Multilevel flag; 1 selects the unsupported format |
| desc_payload | input | PAY_W (96) | Message template forwarded with each request |
| req_valid | output | 1 | Unicast request present |
| req_ready | input | 1 | Consumer takes the request |
| req_node | output | NODE_W (15) | Destination node identifier |
| req_index | output | $clog2(VEC_W) (8) | Vector bit index of this request |
| req_cmd | output | CMD_W (8) | Captured command |
| req_payload | output | PAY_W (96) | Captured payload |
| done | output | 1 | One-cycle end-of-vector pulse |
| err_mode | output | 1 | One-cycle unsupported-mode pulse |

## Verification
The expander is driven with several vectors, each of which exposes a different class of fault:
- A sparse vector with bits 0, 5 and 255 exposes scan-order and top-index faults, and stalls on gaps.
- A dense run under a periodic ready pattern separates correct hold behaviour from lost or repeated requests.
- A base of 0x7FFF shows whether node arithmetic wraps at 15 bits.
- An all-ones vector checks back-to-back issue across every index.
- An empty vector and a multilevel descriptor separate the `done` path from the error path.
- Descriptor offers made while busy show whether the input is properly closed off.

// File: rtl/ucast_pkg.sv
package ucast_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EMIT  = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } ucast_state_t;

endpackage

// File: rtl/ucast_lsb_find.sv
module ucast_lsb_find #(
    parameter int W = 256,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);

    // Lowest set bit wins; scanning downward leaves the smallest index last.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/ucast_node_sum.sv
module ucast_node_sum #(
    parameter int NODE_W = 15,
    parameter int IDX_W  = 8
) (
    input  logic [NODE_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [NODE_W-1:0] node
);

    // Destination identifier wraps modulo 2^NODE_W.
    always_comb begin
        node = base + NODE_W'(idx);
    end

endmodule

// File: rtl/ucast_fanout.sv
module ucast_fanout
    import ucast_pkg::*;
#(
    parameter int VEC_W  = 256,
    parameter int NODE_W = 15,
    parameter int CMD_W  = 8,
    parameter int PAY_W  = 96,
    localparam int IDX_W = $clog2(VEC_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [VEC_W-1:0]  desc_vec,
    input  logic [NODE_W-1:0] desc_base,
    input  logic [CMD_W-1:0]  desc_cmd,
    input  logic              desc_multilevel,
    input  logic [PAY_W-1:0]  desc_payload,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [NODE_W-1:0] req_node,
    output logic [IDX_W-1:0]  req_index,
    output logic [CMD_W-1:0]  req_cmd,
    output logic [PAY_W-1:0]  req_payload,
    output logic              done,
    output logic              err_mode
);

    ucast_state_t      state_q, state_d;
    logic [VEC_W-1:0]  pend_q;
    logic [NODE_W-1:0] base_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [PAY_W-1:0]  pay_q;
    logic [IDX_W-1:0]  lo_idx;
    logic [VEC_W-1:0]  pend_clr;
    logic              accept;
    logic              fire;

    ucast_lsb_find #(.W(VEC_W)) u_find (
        .vec (pend_q),
        .idx (lo_idx)
    );

    ucast_node_sum #(.NODE_W(NODE_W), .IDX_W(IDX_W)) u_sum (
        .base (base_q),
        .idx  (lo_idx),
        .node (req_node)
    );

    assign accept   = (state_q == ST_IDLE) && desc_valid;
    assign fire     = (state_q == ST_EMIT) && req_ready;
    assign pend_clr = pend_q & ~(VEC_W'(1) << lo_idx);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (desc_multilevel)  state_d = ST_FAULT;
                    else if (|desc_vec)   state_d = ST_EMIT;
                    else                  state_d = ST_DONE;
                end
            end
            ST_EMIT: begin
                if (fire && !(|pend_clr)) state_d = ST_DONE;
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Descriptor capture and pending-bit retirement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            base_q <= '0;
            cmd_q  <= '0;
            pay_q  <= '0;
        end else if (accept) begin
            pend_q <= desc_multilevel ? '0 : desc_vec;
            base_q <= desc_base;
            cmd_q  <= desc_cmd;
            pay_q  <= desc_payload;
        end else if (fire) begin
            pend_q <= pend_clr;
        end
    end

    // Outputs
    always_comb begin
        desc_ready = 1'b0;
        req_valid  = 1'b0;
        done       = 1'b0;
        err_mode   = 1'b0;
        unique case (state_q)
            ST_IDLE:  desc_ready = 1'b1;
            ST_EMIT:  req_valid  = 1'b1;
            ST_DONE:  done       = 1'b1;
            ST_FAULT: err_mode   = 1'b1;
        endcase
    end

    assign req_index   = lo_idx;
    assign req_cmd     = cmd_q;
    assign req_payload = pay_q;

    // Assertions
    assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_ready && req_valid));

    assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_valid || (req_index > $past(req_index))));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_node) && $stable(req_index)
                                       && $stable(req_cmd) && $stable(req_payload)));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && desc_ready));

    assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_mode |-> (!done && !req_valid));

    assert_fault_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_mode |=> (!err_mode && desc_ready));

    assert_busy_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !desc_ready);

endmodule

// File: tb/ucast_fanout_tb_top.sv
`timescale 1ns/1ps
module ucast_fanout_tb_top;

    localparam int VW = 256;
    localparam int NW = 15;
    localparam int CW = 8;
    localparam int PW = 96;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          desc_valid;
    logic          desc_ready;
    logic [VW-1:0] desc_vec;
    logic [NW-1:0] desc_base;
    logic [CW-1:0] desc_cmd;
    logic          desc_multilevel;
    logic [PW-1:0] desc_payload;
    logic          req_valid;
    logic          req_ready;
    logic [NW-1:0] req_node;
    logic [IW-1:0] req_index;
    logic [CW-1:0] req_cmd;
    logic [PW-1:0] req_payload;
    logic          done;
    logic          err_mode;

    always #2.5 clk = ~clk;

    ucast_fanout dut_i (
        .clk(clk), .rst_n(rst_n),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_vec(desc_vec), .desc_base(desc_base), .desc_cmd(desc_cmd),
        .desc_multilevel(desc_multilevel), .desc_payload(desc_payload),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_node(req_node), .req_index(req_index), .req_cmd(req_cmd),
        .req_payload(req_payload), .done(done), .err_mode(err_mode)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: 0 idle, 1 sending, 2 end pulse, 3 error pulse
    int            m_mode = 0;
    int            m_q[$];
    logic [NW-1:0] m_base;
    logic [CW-1:0] m_cmd;
    logic [PW-1:0] m_pay;
    bit            m_poke = 0;
    bit            live = 0;
    int            ready_mode = 0;
    int            cyc = 0;
    bit            stall = 0;
    logic [NW-1:0] stall_node;
    logic [PW-1:0] stall_pay;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0;
            m_q.delete();
            m_poke = 0;
        end else begin
            m_poke = desc_valid && (m_mode != 0);
            case (m_mode)
                0: if (desc_valid) begin
                    m_base = desc_base;
                    m_cmd  = desc_cmd;
                    m_pay  = desc_payload;
                    m_q.delete();
                    if (desc_multilevel) m_mode = 3;
                    else begin
                        for (int i = 0; i < VW; i++) if (desc_vec[i]) m_q.push_back(i);
                        m_mode = (m_q.size() == 0) ? 2 : 1;
                    end
                end
                1: if (req_ready) begin
                    void'(m_q.pop_front());
                    if (m_q.size() == 0) m_mode = 2;
                end
                default: m_mode = 0;
            endcase
        end
    end

    // Compare, then drive ready for the next edge
    always @(negedge clk) begin
        cyc++;
        if (live) begin
            if (stall) begin
                chk(req_valid == 1'b1, "R5", "stalled req_valid", 128'(req_valid), 128'(1));
                chk(req_node == stall_node, "R5", "stalled req_node", 128'(req_node), 128'(stall_node));
                chk(req_payload == stall_pay, "R5", "stalled req_payload", 128'(req_payload), 128'(stall_pay));
            end
            chk(desc_ready == (m_mode == 0), m_poke ? "R8" : "R2", "desc_ready",
                128'(desc_ready), 128'(m_mode == 0));
            chk(req_valid == (m_mode == 1), m_poke ? "R8" : "R3", "req_valid",
                128'(req_valid), 128'(m_mode == 1));
            chk(done == (m_mode == 2), "R6", "done", 128'(done), 128'(m_mode == 2));
            chk(err_mode == (m_mode == 3), "R7", "err_mode", 128'(err_mode), 128'(m_mode == 3));
            if (m_mode == 1 && req_valid) begin
                logic [NW-1:0] en;
                en = NW'(m_base + NW'(m_q[0]));
                chk(req_index == IW'(m_q[0]), "R3", "req_index", 128'(req_index), 128'(m_q[0]));
                chk(req_node == en, "R4", "req_node", 128'(req_node), 128'(en));
                chk(req_cmd == m_cmd, "R4", "req_cmd", 128'(req_cmd), 128'(m_cmd));
                chk(req_payload == m_pay, "R4", "req_payload", 128'(req_payload), 128'(m_pay));
            end
        end
        req_ready  = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        stall      = live && req_valid && !req_ready;
        stall_node = req_node;
        stall_pay  = req_payload;
    end

    task automatic run(input logic [VW-1:0] v, input logic [NW-1:0] b, input logic [CW-1:0] c,
                       input logic ml, input logic [PW-1:0] p, input bit poke);
        @(negedge clk);
        while (!desc_ready) @(negedge clk);
        desc_valid = 1'b1; desc_vec = v; desc_base = b; desc_cmd = c;
        desc_multilevel = ml; desc_payload = p;
        @(negedge clk);
        desc_valid = 1'b0;
        if (poke) begin
            desc_valid = 1'b1; desc_vec = '1; desc_base = 15'h1234;
            desc_cmd = 8'hEE; desc_multilevel = 1'b1; desc_payload = '1;
            repeat (3) @(negedge clk);
            desc_valid = 1'b0;
        end
        while (!(done || err_mode)) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [VW-1:0] v;
        rst_n = 1'b0; desc_valid = 1'b0; desc_vec = '0; desc_base = '0;
        desc_cmd = '0; desc_multilevel = 1'b0; desc_payload = '0; req_ready = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(desc_ready == 1'b1, "R1", "desc_ready in reset", 128'(desc_ready), 128'(1));
        chk(req_valid == 1'b0, "R1", "req_valid in reset", 128'(req_valid), 128'(0));
        chk(done == 1'b0, "R1", "done in reset", 128'(done), 128'(0));
        chk(err_mode == 1'b0, "R1", "err_mode in reset", 128'(err_mode), 128'(0));
        rst_n = 1'b1;
        live  = 1'b1;

        // R3/R4: sparse vector, ends included
        v = '0; v[0] = 1'b1; v[5] = 1'b1; v[255] = 1'b1;
        run(v, 15'd100, 8'h38, 1'b0, 96'hA5A5_0000_1111_2222_3333_4444, 1'b0);

        // R5/R8: dense run under backpressure with offers while busy
        ready_mode = 1;
        v = '0; for (int i = 0; i < 10; i++) v[i + 40] = 1'b1;
        run(v, 15'd7, 8'h38, 1'b0, 96'h1, 1'b1);

        // R4: node wrap
        v = '0; v[1] = 1'b1; v[2] = 1'b1;
        run(v, 15'h7FFF, 8'h11, 1'b0, 96'h2, 1'b0);
        ready_mode = 0;

        // R6: empty vector
        run('0, 15'd5, 8'h38, 1'b0, 96'h3, 1'b0);

        // R7: multilevel descriptor
        run('1, 15'd9, 8'h38, 1'b1, 96'h4, 1'b0);

        // R3: every bit set
        run('1, 15'd300, 8'h38, 1'b0, 96'h5, 1'b0);

        // R6: empty again straight after a full run
        run('0, 15'd0, 8'h22, 1'b0, 96'h6, 1'b0);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule